// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Write Unlock

This block is a watchdog timer with a small byte-addressed register port. Once software enables it, a down counter runs through two stages. The first stage counts down from one preload value, and its end can raise a timeout output. The second stage counts down from a second preload value, and its end sets a sticky timeout flag and can request a system reset. After the second stage the countdown starts over with the first stage. Software keeps the system alive by sending reload commands before the second stage runs out.

The preload values and the reload/flag-clear command are protected. A write to any of them takes effect only when it follows a two-byte key sequence. One key sequence opens the door for exactly one protected write. A lock bit freezes the enable bits and the configuration until the next power-on reset.

The block has two resets. The power-on reset clears everything. The system reset that the watchdog itself triggers clears only the counter, the prescaler, the outputs and the key-sequence state. The preload values, the configuration, the lock register and the timeout flag keep their values.

Top module: `guard_timer`

## Requirements
- R1: After power-on reset, the register at byte offset 0x18 reads 0, the register at 0x0D reads 0, the register at 0x10 reads 0, both preload registers (0x00 and 0x04) read all ones, and `rst_req` and `tmo_out` are low.
- R2: Writing 0x80 and then 0x86 to offset 0x0C opens exactly one protected write. The protected offsets are 0x00 (preload 1), 0x04 (preload 2) and 0x0D (command). A second protected write needs a new key sequence. Repeating 0x80 before 0x86 is still a valid sequence.
- R3: The key sequence is abandoned, and the next protected write is ignored, in these cases: another register is written between the two key bytes, or 0x80 is followed by any byte other than 0x86.
- R4: Writing 1 to bit 0 of offset 0x0D after a key sequence reloads the first stage from preload 1. Offset 0x14 is read-only and returns the current stage count. The count falls by one on each tick.
- R5: Ticks come every 2^COARSE_SH clocks when configuration bit 2 is 1, and every 2^FINE_SH clocks when it is 0. After enable, the first stage ends on tick pv1+1. The second stage ends on tick pv1+pv2+2, and the first stage then restarts.
- R6: Configuration bit 5 enables `tmo_out` at the end of the first stage. Bit 2 of offset 0x18 selects how `tmo_out` responds: 0 gives a one-cycle pulse, 1 toggles the level.
- R7: Configuration bit 4 enables `rst_req` at the end of the second stage. Configuration bit 3 selects how `rst_req` behaves: 1 holds it until a reset, 0 gives a one-cycle pulse.
- R8: Bit 1 of offset 0x0D is the timeout flag. It is set at the end of every second stage, and is set even when the reset output is disabled. It is cleared only by writing 1 to it after a key sequence, or by power-on reset. It survives the system reset.
- R9: Bit 0 of offset 0x18 is the lock. Once it is set, it stays set, and writes no longer change bits 1 and 2 of 0x18 or the configuration at 0x10. Only power-on reset clears it.
- R10: Bit 1 of offset 0x18 enables counting. Writing 0 to it stops the countdown: the count holds and no output fires.
- R11: A system reset returns the counter, prescaler, outputs and key-sequence state to idle, and the counter then reloads from preload 1. Preloads, configuration, lock register and timeout flag keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data; byte registers use bits 7:0 |
| rdata | output | 32 | Read data for `addr`, combinational |
| tmo_out | output | 1 | Timeout output at the end of the first stage |
| rst_req | output | 1 | Reset request at the end of the second stage |

## Verification
The hardest situation to reach from the ports is a system reset that arrives while a reset request is being held. In that situation the bench must show that the flag, the configuration and the enable survive, while the key state and the outputs are cleared. The stimulus gets there in the following order. It first sets hold mode and runs a short countdown into a timeout. It then opens a key sequence, pulses the system reset, and tries a protected write that must now be refused. Stage-end timing is swept over every small pair of preload values under both tick rates. The first edge of each output is compared with tick counts computed in the bench.

// File: rtl/guard_pkg.sv
package guard_pkg;

    // byte offsets; software-visible, so fixed
    localparam logic [4:0] OFS_PV1 = 5'h00;
    localparam logic [4:0] OFS_PV2 = 5'h04;
    localparam logic [4:0] OFS_KEY = 5'h0C;
    localparam logic [4:0] OFS_CMD = 5'h0D;
    localparam logic [4:0] OFS_CFG = 5'h10;
    localparam logic [4:0] OFS_CNT = 5'h14;
    localparam logic [4:0] OFS_LCK = 5'h18;

    localparam logic [7:0] KEY_FIRST  = 8'h80;
    localparam logic [7:0] KEY_SECOND = 8'h86;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_HALF = 2'd1,
        UL_OPEN = 2'd2
    } ul_state_e;

    // configuration byte bits 5..2
    typedef struct packed {
        logic tmo_en;
        logic rst_en;
        logic rst_hold;
        logic coarse;
    } cfg_t;

    // lock byte bits 2..0
    typedef struct packed {
        logic tmo_toggle;
        logic run;
        logic lock;
    } lck_t;

endpackage

// File: rtl/gt_unlock.sv
module gt_unlock
    import guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [4:0] addr,
    input  logic [7:0] wbyte,
    output logic       grant,
    output logic       armed
);

    ul_state_e state_d, state_q;
    logic      is_protected;

    assign is_protected = (addr == OFS_PV1) || (addr == OFS_PV2) || (addr == OFS_CMD);

    always_comb begin
        state_d = state_q;
        grant   = 1'b0;
        if (wr_en) begin
            if (addr == OFS_KEY) begin
                if (wbyte == KEY_FIRST)
                    state_d = UL_HALF;
                else if (wbyte == KEY_SECOND && state_q == UL_HALF)
                    state_d = UL_OPEN;
                else
                    state_d = UL_IDLE;
            end else begin
                // any other write consumes or abandons the sequence
                grant   = (state_q == UL_OPEN) && is_protected;
                state_d = UL_IDLE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= UL_IDLE;
        else        state_q <= state_d;
    end

    assign armed = (state_q == UL_OPEN);

endmodule

// File: rtl/gt_prescale.sv
module gt_prescale #(
    parameter int FINE_SH   = 5,
    parameter int COARSE_SH = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic clear,
    input  logic coarse,
    output logic tick
);

    logic [COARSE_SH-1:0] psc_d, psc_q;
    logic                 wrap;

    generate
        if (FINE_SH >= COARSE_SH) begin : g_flat
            // degenerate setting: both rates use the full divider
            assign wrap = &psc_q;
        end else begin : g_split
            assign wrap = coarse ? (&psc_q) : (&psc_q[FINE_SH-1:0]);
        end
    endgenerate

    assign tick = run && wrap;

    always_comb begin
        if (!run || clear || tick)
            psc_d = '0;
        else
            psc_d = psc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) psc_q <= '0;
        else        psc_q <= psc_d;
    end

endmodule

// File: rtl/gt_stage_cnt.sv
module gt_stage_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             reload,
    input  logic [CNT_W-1:0] pv1,
    input  logic [CNT_W-1:0] pv2,
    output logic [CNT_W-1:0] cnt,
    output logic             fresh,
    output logic             end1,
    output logic             end2
);

    typedef struct packed {
        logic             fresh;
        logic             stage2;
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        end1 = 1'b0;
        end2 = 1'b0;
        if (st_q.fresh || reload) begin
            st_d.fresh  = 1'b0;
            st_d.stage2 = 1'b0;
            st_d.cnt    = pv1;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                if (!st_q.stage2) begin
                    end1        = 1'b1;
                    st_d.stage2 = 1'b1;
                    st_d.cnt    = pv2;
                end else begin
                    end2        = 1'b1;
                    st_d.stage2 = 1'b0;
                    st_d.cnt    = pv1;
                end
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fresh: 1'b1, stage2: 1'b0, cnt: '0};
        else        st_q <= st_d;
    end

    assign cnt   = st_q.cnt;
    assign fresh = st_q.fresh;

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter int CNT_W     = 32,
    parameter int FINE_SH   = 5,
    parameter int COARSE_SH = 15
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        sys_rst_n,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        tmo_out,
    output logic        rst_req
);

    localparam int BUS_W = 32;

    // state kept across the watchdog's own reset
    typedef struct packed {
        logic [CNT_W-1:0] pv1;
        logic [CNT_W-1:0] pv2;
        cfg_t             cfg;
        lck_t             lck;
        logic             flag;
    } keep_st_t;

    // state cleared by either reset
    typedef struct packed {
        logic tmo;
        logic rst;
    } out_st_t;

    keep_st_t kp_d, kp_q;
    out_st_t  ot_d, ot_q;

    logic             any_rst_n;
    logic             grant, armed;
    logic             reload, tick;
    logic             end1, end2;
    logic             cnt_fresh;
    logic [CNT_W-1:0] cnt_val;

    // plain views for the bound checker
    logic       sticky_flag, lock_bit, run_bit, toggle_bit, hold_bit;
    logic [3:0] cfg_bits;

    assign any_rst_n = por_n & sys_rst_n;

    gt_unlock u_unlock (
        .clk   (clk),
        .rst_n (any_rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wbyte (wdata[7:0]),
        .grant (grant),
        .armed (armed)
    );

    assign reload = wr_en && (addr == OFS_CMD) && grant && wdata[0];

    gt_prescale #(
        .FINE_SH   (FINE_SH),
        .COARSE_SH (COARSE_SH)
    ) u_prescale (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .run    (kp_q.lck.run),
        .clear  (reload),
        .coarse (kp_q.cfg.coarse),
        .tick   (tick)
    );

    gt_stage_cnt #(
        .CNT_W (CNT_W)
    ) u_stage (
        .clk    (clk),
        .rst_n  (any_rst_n),
        .tick   (tick),
        .reload (reload),
        .pv1    (kp_q.pv1),
        .pv2    (kp_q.pv2),
        .cnt    (cnt_val),
        .fresh  (cnt_fresh),
        .end1   (end1),
        .end2   (end2)
    );

    // next value of the retained registers
    always_comb begin
        kp_d = kp_q;
        if (wr_en) begin
            case (addr)
                OFS_PV1: if (grant) kp_d.pv1 = wdata[CNT_W-1:0];
                OFS_PV2: if (grant) kp_d.pv2 = wdata[CNT_W-1:0];
                OFS_CMD: if (grant && wdata[1]) kp_d.flag = 1'b0;
                OFS_CFG: if (!kp_q.lck.lock)
                    kp_d.cfg = '{tmo_en: wdata[5], rst_en: wdata[4],
                                 rst_hold: wdata[3], coarse: wdata[2]};
                OFS_LCK: if (!kp_q.lck.lock)
                    kp_d.lck = '{tmo_toggle: wdata[2], run: wdata[1], lock: wdata[0]};
                default: ;
            endcase
        end
        // a timeout wins over a clear in the same cycle
        if (end2) kp_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)
            kp_q <= '{pv1: '1, pv2: '1, cfg: '0, lck: '0, flag: 1'b0};
        else
            kp_q <= kp_d;
    end

    // next value of the outputs
    always_comb begin
        ot_d = ot_q;
        if (end1 && kp_q.cfg.tmo_en)
            ot_d.tmo = kp_q.lck.tmo_toggle ? ~ot_q.tmo : 1'b1;
        else if (!kp_q.lck.tmo_toggle)
            ot_d.tmo = 1'b0;

        if (end2 && kp_q.cfg.rst_en)
            ot_d.rst = 1'b1;
        else if (!kp_q.cfg.rst_hold)
            ot_d.rst = 1'b0;
    end

    always_ff @(posedge clk or negedge any_rst_n) begin
        if (!any_rst_n) ot_q <= '0;
        else            ot_q <= ot_d;
    end

    assign tmo_out = ot_q.tmo;
    assign rst_req = ot_q.rst;

    // read mux
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_PV1: rdata[CNT_W-1:0] = kp_q.pv1;
            OFS_PV2: rdata[CNT_W-1:0] = kp_q.pv2;
            OFS_CMD: rdata[1]         = kp_q.flag;
            OFS_CFG: rdata[5:2]       = kp_q.cfg;
            OFS_CNT: rdata[CNT_W-1:0] = cnt_val;
            OFS_LCK: rdata[2:0]       = kp_q.lck;
            default: rdata = '0;
        endcase
    end

    assign sticky_flag = kp_q.flag;
    assign lock_bit    = kp_q.lck.lock;
    assign run_bit     = kp_q.lck.run;
    assign toggle_bit  = kp_q.lck.tmo_toggle;
    assign hold_bit    = kp_q.cfg.rst_hold;
    assign cfg_bits    = kp_q.cfg;

    if (CNT_W > BUS_W) begin : g_bad_width
        $error("CNT_W must not exceed the bus width");
    end

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             por_n,
    input logic             sys_rst_n,
    input logic             wr_en,
    input logic             rst_req,
    input logic             tmo_out,
    input logic             sticky_flag,
    input logic             lock_bit,
    input logic             run_bit,
    input logic             toggle_bit,
    input logic             hold_bit,
    input logic [3:0]       cfg_bits,
    input logic             grant,
    input logic             armed,
    input logic             cnt_fresh,
    input logic [CNT_W-1:0] cnt_val
);

    // R8: a reset request never appears without the flag
    p_flag_with_rst_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        $rose(rst_req) |-> sticky_flag);

    // R7: pulse mode gives a single-cycle request
    p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (rst_req && !hold_bit) |=> !rst_req);

    // R6: pulse mode gives a single-cycle timeout output
    p_tmo_pulse_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (tmo_out && !toggle_bit) |=> !tmo_out);

    // R9: the lock stays set
    p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        lock_bit |=> lock_bit);

    // R9: locked fields are frozen
    p_lock_freeze_r9: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        lock_bit |=> $stable({run_bit, toggle_bit, cfg_bits}));

    // R2: a granted write uses up the key sequence
    p_single_use_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        grant |=> !armed);

    // R10: a stopped counter holds its value
    p_stopped_hold_r10: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
        (!run_bit && !wr_en && !cnt_fresh) |=> $stable(cnt_val));

endmodule

bind guard_timer guard_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .por_n       (por_n),
    .sys_rst_n   (sys_rst_n),
    .wr_en       (wr_en),
    .rst_req     (rst_req),
    .tmo_out     (tmo_out),
    .sticky_flag (sticky_flag),
    .lock_bit    (lock_bit),
    .run_bit     (run_bit),
    .toggle_bit  (toggle_bit),
    .hold_bit    (hold_bit),
    .cfg_bits    (cfg_bits),
    .grant       (grant),
    .armed       (armed),
    .cnt_fresh   (cnt_fresh),
    .cnt_val     (cnt_val)
);

// File: tb/sim_guard_timer.sv
module sim_guard_timer;

    localparam int CNT_W     = 8;
    localparam int FINE_SH   = 2;
    localparam int COARSE_SH = 4;

    localparam logic [4:0] A_PV1 = 5'h00, A_PV2 = 5'h04, A_KEY = 5'h0C,
                           A_CMD = 5'h0D, A_CFG = 5'h10, A_CNT = 5'h14, A_LCK = 5'h18;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tmo_out, rst_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    guard_timer #(
        .CNT_W     (CNT_W),
        .FINE_SH   (FINE_SH),
        .COARSE_SH (COARSE_SH)
    ) u0 (
        .clk       (clk),
        .por_n     (por_n),
        .sys_rst_n (sys_rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .tmo_out   (tmo_out),
        .rst_req   (rst_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic key();
        wr(A_KEY, 32'h80);
        wr(A_KEY, 32'h86);
    endtask

    task automatic setup(input int p1, input int p2, input logic [31:0] cfg);
        key(); wr(A_PV1, p1);
        key(); wr(A_PV2, p2);
        key(); wr(A_CMD, 32'h1);
        wr(A_CFG, cfg);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        step(3);
        por_n = 1'b1; sys_rst_n = 1'b1;
        step(2);

        // R1: reset state
        peek(A_LCK, v); chk("R1 lock reg", v, 0);
        peek(A_CMD, v); chk("R1 cmd reg", v, 0);
        peek(A_CFG, v); chk("R1 cfg reg", v, 0);
        peek(A_PV1, v); chk("R1 pv1", v, 32'hFF);
        peek(A_PV2, v); chk("R1 pv2", v, 32'hFF);
        chk("R1 rst_req", rst_req, 0);
        chk("R1 tmo_out", tmo_out, 0);
        peek(A_CNT, v); chk("R11 count loads pv1 after reset", v, 32'hFF);

        // R3: broken key sequences
        wr(A_KEY, 32'h80); wr(A_CFG, 32'h0); wr(A_KEY, 32'h86); wr(A_PV1, 32'h11);
        peek(A_PV1, v); chk("R3 write between key bytes", v, 32'hFF);
        wr(A_KEY, 32'h80); wr(A_KEY, 32'h81); wr(A_KEY, 32'h86); wr(A_PV1, 32'h12);
        peek(A_PV1, v); chk("R3 wrong second byte", v, 32'hFF);
        // R2: repeated first byte still valid, single use
        wr(A_KEY, 32'h80); wr(A_KEY, 32'h80); wr(A_KEY, 32'h86); wr(A_PV1, 32'h22);
        peek(A_PV1, v); chk("R2 key opens write", v, 32'h22);
        wr(A_PV1, 32'h33);
        peek(A_PV1, v); chk("R2 second write refused", v, 32'h22);

        // R4/R10: count readback, stop holds count
        setup(5, 3, 32'h0);
        peek(A_CNT, v); chk("R4 reload loads pv1", v, 5);
        wr(A_LCK, 32'h2);
        step(8);
        peek(A_CNT, v); chk("R4 count after two ticks", v, 3);
        wr(A_LCK, 32'h0);
        step(20);
        peek(A_CNT, v); chk("R10 count held when stopped", v, 3);
        chk("R10 no reset when stopped", rst_req, 0);

        // R5/R7/R8: sweep of preloads and tick rates
        for (int c = 0; c < 2; c++) begin
            for (int p1 = 0; p1 < 4; p1++) begin
                for (int p2 = 0; p2 < 4; p2++) begin
                    int per, e1, e2, t1, t2, wid;
                    per = (c == 1) ? (1 << COARSE_SH) : (1 << FINE_SH);
                    e1 = (p1 + 1) * per;
                    e2 = (p1 + p2 + 2) * per;
                    setup(p1, p2, 32'h30 | (c << 2));
                    wr(A_LCK, 32'h2);
                    t1 = 0; t2 = 0; wid = 0;
                    for (int n = 1; n <= e2 + 2; n++) begin
                        step(1);
                        if (tmo_out && t1 == 0) t1 = n;
                        if (rst_req) begin
                            if (t2 == 0) t2 = n;
                            wid++;
                        end
                    end
                    chk("R5 first stage end", t1, e1);
                    chk("R5 second stage end", t2, e2);
                    chk("R7 pulse width", wid, 1);
                    peek(A_CMD, v); chk("R8 flag set", v, 32'h2);
                    wr(A_LCK, 32'h0);
                    key(); wr(A_CMD, 32'h2);
                    peek(A_CMD, v); chk("R8 flag cleared", v, 0);
                end
            end
        end

        // R6: toggle mode, reset disabled
        setup(0, 1, 32'h20);
        wr(A_LCK, 32'h6);
        step(5);
        chk("R6 toggle first edge", tmo_out, 1);
        step(8);
        chk("R6 toggle level kept", tmo_out, 1);
        chk("R7 reset disabled", rst_req, 0);
        peek(A_CMD, v); chk("R8 flag set without reset", v, 32'h2);
        step(4);
        chk("R6 toggle back", tmo_out, 0);
        wr(A_LCK, 32'h0);
        key(); wr(A_CMD, 32'h2);

        // R6/R7: output disabled, hold mode
        setup(0, 0, 32'h18);
        wr(A_LCK, 32'h2);
        begin
            int hits;
            hits = 0;
            for (int n = 1; n <= 9; n++) begin
                step(1);
                if (tmo_out) hits++;
            end
            chk("R6 output disabled", hits, 0);
        end
        chk("R7 hold asserted", rst_req, 1);
        step(10);
        chk("R7 hold kept", rst_req, 1);

        // R11: system reset with key open
        wr(A_KEY, 32'h80); wr(A_KEY, 32'h86);
        sys_rst_n = 1'b0;
        step(2);
        sys_rst_n = 1'b1;
        chk("R11 reset request cleared", rst_req, 0);
        peek(A_CMD, v); chk("R8 flag survives system reset", v, 32'h2);
        peek(A_CFG, v); chk("R11 cfg kept", v, 32'h18);
        peek(A_LCK, v); chk("R11 enable kept", v, 32'h2);
        wr(A_PV1, 32'h44);
        peek(A_PV1, v); chk("R11 key state cleared", v, 0);
        wr(A_LCK, 32'h0);
        chk("R11 no new request", rst_req, 0);
        wr(A_CMD, 32'h2);
        peek(A_CMD, v); chk("R8 clear needs key", v, 32'h2);
        key(); wr(A_CMD, 32'h2);
        peek(A_CMD, v); chk("R8 clear with key", v, 0);

        // R9: lock
        wr(A_LCK, 32'h3);
        wr(A_LCK, 32'h0);
        peek(A_LCK, v); chk("R9 locked enable", v, 32'h3);
        wr(A_CFG, 32'h3C);
        peek(A_CFG, v); chk("R9 locked cfg", v, 32'h18);
        sys_rst_n = 1'b0;
        step(2);
        sys_rst_n = 1'b1;
        peek(A_LCK, v); chk("R9 lock survives system reset", v, 32'h3);
        por_n = 1'b0;
        step(2);
        por_n = 1'b1;
        step(1);
        peek(A_LCK, v); chk("R9 power-on clears lock", v, 0);
        peek(A_CFG, v); chk("R1 cfg after power-on", v, 0);
        chk("R1 rst_req after power-on", rst_req, 0);

        done = 1;
        summary();
        $finish;
    end

endmodule